// File: doc/BRIEF.md
# Display Identification Fetch and Checksum Sequencer

This block fetches the identification data of an attached display sink over a single byte-wide request/response port. The port stands in for the auxiliary-channel I2C transactions that a link controller would issue; the bus itself is not modelled. After a start pulse the sequencer first reads the byte that tells how many extension blocks follow. It then reads one 128-byte block, or two back to back when that count is nonzero. Each block is accepted only if its bytes add up to zero modulo 256.

When the data is valid, the sequencer reads the sink's test-request register. If the sink asks for an identification-read test, the sequencer writes the last byte of the last block read into the sink's test-checksum register, then writes a flag into its test-response register. Every fetched byte stays in a local buffer that the rest of the controller reads through a combinational read port. A one-cycle done pulse reports a 2-bit result code.

Top module: `edid_fetch_seq`

## Requirements
- R1: The first transaction after start reads offset 126 of the identification device. Every identification-space transaction (bus_cfg=0) is a read (bus_we=0) to 7-bit device address 0x50.
- R2: If the extension byte is 0, the sequencer reads offsets 0..127 in ascending order. If it is nonzero, it reads offsets 0..255 in ascending order, and block 1 (offsets 128..255) is read only after block 0 has passed its check.
- R3: Each byte read from offset k (0..255) is stored so that, after completion, buf_rdata shows it in the same cycle buf_raddr equals k.
- R4: If the 8-bit wrapping sum of a block's 128 bytes is not zero, the run ends with status 2 and no further transaction is issued.
- R5: A transaction answered with bus_err=1 ends the run with status 1, and no further transaction is issued.
- R6: After all blocks pass, the sequencer reads config-space (bus_cfg=1) address 0x0218. If bit 2 of that byte is set, it writes the byte at offset 127 of the last block read to address 0x0261, then writes 0x04 to address 0x0260. If bit 2 is clear, it writes nothing. In both cases the status is 0.
- R7: bus_req, once raised, stays high with stable address, direction and space select until the cycle in which bus_ack is high. bus_req is then low for the following cycle, so only one transaction is ever outstanding.
- R8: done is a one-cycle pulse. status holds 0 (ok), 1 (transfer error) or 2 (bad checksum) and keeps that value until the next accepted start. busy is high from the accepted start until done.
- R9: A start pulse while busy is high is ignored: no second run, and no extra done pulse.
- R10: After reset, busy, done, bus_req and status are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fetch (ignored while busy) |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result: 0 ok, 1 transfer error, 2 bad checksum |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_cfg | output | 1 | 1 = sink config space, 0 = identification device |
| bus_dev | output | 7 | Identification device address |
| bus_addr | output | 16 | Byte offset or config register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transaction complete |
| bus_err | input | 1 | Transaction failed (valid with bus_ack) |
| bus_rdata | input | 8 | Read data (valid with bus_ack) |
| buf_raddr | input | 8 | Buffer read address |
| buf_rdata | output | 8 | Buffer byte at buf_raddr |

## Verification
The fetch is tried with a zero and a nonzero extension byte, which separates the one-block path from the two-block path by the transaction count and the buffer contents. A corrupted byte is placed first in block 0 and then in block 1, to show that each block is checked on its own and that the run stops at the failing block. Transfer errors are injected on the very first read and in mid-block, so an abort at the first transaction can be told apart from one partway through. The test-request bit is toggled, and the written checksum is compared against block 0's last byte on the one-block path and against block 1's last byte on the two-block path. A slower responder checks that the handshake does not depend on the acknowledge latency.

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq #(
  parameter logic [6:0]  DEV_ADDR   = 7'h50,
  parameter int          BLK_BYTES  = 128,
  parameter int          AW         = 16,
  parameter int          EXT_OFS    = 126,
  parameter logic [15:0] TREQ_ADDR  = 16'h0218,
  parameter logic [15:0] TCSUM_ADDR = 16'h0261,
  parameter logic [15:0] TRESP_ADDR = 16'h0260,
  parameter int          TREQ_BIT   = 2,
  parameter logic [7:0]  TRESP_FLAG = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_cfg,
  output logic [6:0]    bus_dev,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [7:0]    bus_rdata,
  input  logic [7:0]    buf_raddr,
  output logic [7:0]    buf_rdata
);
  localparam int BUF_BYTES = 2 * BLK_BYTES;
  localparam int IW = $clog2(BUF_BYTES);
  localparam int OW = $clog2(BLK_BYTES);
  localparam logic [1:0] ST_OK = 2'd0, ST_XERR = 2'd1, ST_CSUM = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_EXT, S_BLK, S_TREQ, S_TCS, S_TRSP} state_t;

  state_t       state;
  logic [IW-1:0] idx;
  logic [7:0]   sum, last_ck;
  logic         two_blk, gap;
  logic [7:0]   mem [BUF_BYTES];

  wire       xfer    = bus_req && bus_ack;
  wire [7:0] sum_nx  = sum + bus_rdata;
  wire       blk_end = idx[OW-1:0] == OW'(BLK_BYTES - 1);

  assign busy      = state != S_IDLE;
  assign bus_req   = busy && !gap;
  assign bus_dev   = DEV_ADDR;
  assign buf_rdata = mem[buf_raddr[IW-1:0]];

  always_comb begin
    bus_we    = 1'b0;
    bus_cfg   = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      S_EXT:  bus_addr = AW'(EXT_OFS);
      S_BLK:  bus_addr = AW'(idx);
      S_TREQ: begin bus_cfg = 1'b1; bus_addr = TREQ_ADDR; end
      S_TCS:  begin bus_cfg = 1'b1; bus_we = 1'b1; bus_addr = TCSUM_ADDR; bus_wdata = last_ck; end
      S_TRSP: begin bus_cfg = 1'b1; bus_we = 1'b1; bus_addr = TRESP_ADDR; bus_wdata = TRESP_FLAG; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      sum     <= '0;
      last_ck <= '0;
      two_blk <= 1'b0;
      gap     <= 1'b0;
      done    <= 1'b0;
      status  <= ST_OK;
    end else begin
      done <= 1'b0;
      gap  <= xfer;
      case (state)
        S_IDLE: if (start) begin
          state  <= S_EXT;
          idx    <= '0;
          sum    <= '0;
          status <= ST_OK;
        end
        S_EXT: if (xfer) begin
          if (bus_err) begin
            state <= S_IDLE; done <= 1'b1; status <= ST_XERR;
          end else begin
            two_blk <= |bus_rdata;
            state   <= S_BLK;
          end
        end
        S_BLK: if (xfer) begin
          if (bus_err) begin
            state <= S_IDLE; done <= 1'b1; status <= ST_XERR;
          end else if (!blk_end) begin
            sum <= sum_nx;
            idx <= idx + 1'b1;
          end else if (sum_nx != 8'd0) begin
            state <= S_IDLE; done <= 1'b1; status <= ST_CSUM;
          end else begin
            last_ck <= bus_rdata;
            sum     <= '0;
            if (two_blk && !idx[IW-1]) idx <= idx + 1'b1;
            else state <= S_TREQ;
          end
        end
        S_TREQ: if (xfer) begin
          if (bus_err) begin
            state <= S_IDLE; done <= 1'b1; status <= ST_XERR;
          end else if (bus_rdata[TREQ_BIT]) begin
            state <= S_TCS;
          end else begin
            state <= S_IDLE; done <= 1'b1; status <= ST_OK;
          end
        end
        S_TCS: if (xfer) begin
          if (bus_err) begin
            state <= S_IDLE; done <= 1'b1; status <= ST_XERR;
          end else state <= S_TRSP;
        end
        S_TRSP: if (xfer) begin
          state  <= S_IDLE;
          done   <= 1'b1;
          status <= bus_err ? ST_XERR : ST_OK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (state == S_BLK && xfer && !bus_err) mem[idx] <= bus_rdata;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_cfg));
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);
  p_devaddr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_cfg |-> bus_dev == DEV_ADDR && !bus_we);
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 2'd3 && !bus_req);
  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && bus_err |=> !busy);
  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(status));
endmodule

// File: tb/edid_fetch_seq_test.sv
`timescale 1ns/1ps
module edid_fetch_seq_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, bus_req, bus_we, bus_cfg;
  logic [1:0] status;
  logic [6:0] bus_dev;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, buf_rdata;
  logic bus_ack = 0, bus_err = 0;
  logic [7:0] bus_rdata = 0, buf_raddr = 0;

  edid_fetch_seq uut (.clk, .rst_n, .start, .busy, .done, .status, .bus_req, .bus_we,
    .bus_cfg, .bus_dev, .bus_addr, .bus_wdata, .bus_ack, .bus_err, .bus_rdata,
    .buf_raddr, .buf_rdata);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] img [256];
  logic [7:0] treq_val = 0;
  int txn = 0, fail_at = -1, lat = 0, wcnt = 0, dones = 0;
  int first_addr = -1, n_cs = 0, n_rsp = 0, bad_seq = 0, bad_dev = 0;
  logic [7:0] cs_val = 0, rsp_val = 0;
  logic order_ok = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (done) dones++;
    if (bus_ack) begin
      bus_ack = 0; bus_err = 0;
    end else if (bus_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0; txn++;
        if (txn == 1) first_addr = int'(bus_addr);
        if (!bus_cfg && (bus_dev != 7'h50 || bus_we)) bad_dev++;
        if (!bus_cfg && txn > 1 && bus_addr != 16'(txn - 2)) bad_seq++;
        if (bus_cfg && bus_we && bus_addr == 16'h0261) begin n_cs++; cs_val = bus_wdata; end
        if (bus_cfg && bus_we && bus_addr == 16'h0260) begin
          n_rsp++; rsp_val = bus_wdata;
          if (n_cs == 0) order_ok = 0;
        end
        bus_rdata = bus_cfg ? (bus_addr == 16'h0218 ? treq_val : 8'h00) : img[bus_addr[7:0]];
        bus_err = (txn == fail_at);
        bus_ack = 1;
      end
    end
  end

  task automatic build(input bit ext, input int seed, input bit bad0, input bit bad1);
    for (int b = 0; b < 2; b++) begin
      logic [7:0] s = 0;
      for (int i = 0; i < 127; i++) begin
        logic [7:0] v = 8'((i * seed + b * 31 + 5));
        if (i == 126) v = (b == 0 && ext) ? 8'd1 : 8'd0;
        img[b*128+i] = v; s += v;
      end
      img[b*128+127] = 8'(-s);
    end
    if (bad0) img[5] ^= 8'h01;
    if (bad1) img[133] ^= 8'h10;
  endtask

  task automatic run(input bit restart_mid);
    txn = 0; dones = 0; n_cs = 0; n_rsp = 0; bad_seq = 0; bad_dev = 0;
    first_addr = -1; order_ok = 1;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    if (restart_mid) begin
      repeat (20) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic chk_buf(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      buf_raddr = 8'(i); #1;
      if (buf_rdata != img[i]) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !bus_req && status == 0, "R10 reset state",
        {busy, done, bus_req, status}, 0);
  endtask

  task automatic t_one_block;
    build(0, 3, 0, 0); treq_val = 0; fail_at = -1; lat = 0;
    run(0);
    chk(status == 0, "R8 one-block status", status, 0);
    chk(dones == 1, "R8 single done pulse", dones, 1);
    chk(first_addr == 126, "R1 extension byte read first", first_addr, 126);
    chk(bad_dev == 0, "R1 identification reads to 0x50", bad_dev, 0);
    chk(txn == 130, "R2 one-block transaction count", txn, 130);
    chk(bad_seq == 0, "R2 ascending offsets", bad_seq, 0);
    chk(n_cs == 0 && n_rsp == 0, "R6 no write without test request", n_cs + n_rsp, 0);
    chk_buf(128, "R3 buffer block 0");
  endtask

  task automatic t_two_block_test;
    build(1, 7, 0, 0); treq_val = 8'h04; fail_at = -1; lat = 2;
    run(0);
    chk(status == 0, "R8 two-block status", status, 0);
    chk(txn == 260, "R2 two-block transaction count", txn, 260);
    chk(bad_seq == 0, "R2 ascending offsets 0..255", bad_seq, 0);
    chk(n_cs == 1 && cs_val == img[255], "R6 checksum of block 1 written", cs_val, img[255]);
    chk(n_rsp == 1 && rsp_val == 8'h04 && order_ok, "R6 response flag after checksum", rsp_val, 4);
    chk_buf(256, "R3 buffer both blocks");
    repeat (5) @(negedge clk);
    chk(status == 0 && !busy, "R8 status held when idle", status, 0);
  endtask

  task automatic t_one_block_test;
    build(0, 11, 0, 0); treq_val = 8'h04; fail_at = -1; lat = 0;
    run(0);
    chk(n_cs == 1 && cs_val == img[127], "R6 checksum of block 0 written", cs_val, img[127]);
    chk(txn == 132, "R6 one-block with test count", txn, 132);
  endtask

  task automatic t_bad_blk0;
    build(1, 5, 1, 0); treq_val = 8'h04; fail_at = -1; lat = 0;
    run(0);
    chk(status == 2, "R4 bad block 0 status", status, 2);
    chk(txn == 129, "R4 stop after block 0", txn, 129);
  endtask

  task automatic t_bad_blk1;
    build(1, 9, 0, 1); treq_val = 8'h04; fail_at = -1; lat = 1;
    run(0);
    chk(status == 2, "R4 bad block 1 status", status, 2);
    chk(txn == 257 && n_cs == 0, "R4 stop after block 1", txn, 257);
  endtask

  task automatic t_err_mid;
    build(1, 13, 0, 0); treq_val = 0; fail_at = 50; lat = 0;
    run(0);
    chk(status == 1, "R5 mid-block error status", status, 1);
    chk(txn == 50, "R5 no transaction after error", txn, 50);
  endtask

  task automatic t_err_first;
    build(0, 3, 0, 0); treq_val = 0; fail_at = 1; lat = 0;
    run(0);
    chk(status == 1, "R5 error on extension read", status, 1);
    chk(txn == 1, "R5 single transaction", txn, 1);
  endtask

  task automatic t_restart;
    build(0, 17, 0, 0); treq_val = 0; fail_at = -1; lat = 0;
    run(1);
    chk(dones == 1, "R9 start while busy ignored", dones, 1);
    chk(txn == 130 && status == 0, "R9 run unchanged", txn, 130);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_one_block();
    t_two_block_test();
    t_one_block_test();
    t_bad_blk0();
    t_bad_blk1();
    t_err_mid();
    t_err_first();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule